// File: doc/BRIEF.md
# Configurable Interrupt Controller

This block collects up to 32 interrupt requests from other logic and turns them into two summary requests for a parent processor or a parent controller. Each source is retimed through a synchronizer. It is then checked against its own sensing rule: either a level that is active high or active low, or a transition that is rising or falling. A source that meets its rule latches a bit in a status word, and that bit stays set until software clears it by writing a one to it.

A per-source enable word masks the status word, and the result can be read back. A per-source critical-select word then decides whether each enabled, pending source drives the normal request output or the critical request output. Software reaches all words through a simple register port. Writes are single-cycle and reads are combinational. Two vector words are plain storage for now.

Top module: `intc_top`

## Requirements
- R1: After reset, status, enable, critical select, trigger and both vector words read zero, polarity reads all ones, and both request outputs are low.
- R2: Source n (srcIn[n]) owns bit 31−n of every per-source word; for example, source 0 is bit 31 and source 10 is bit 21.
- R3: With trigger bit 1 (edge), a source latches its status bit only on the selected transition: rising when polarity is 1, falling when polarity is 0. The bit stays set after the input returns.
- R4: With trigger bit 0 (level), a source sets its status bit whenever its synchronized input equals the polarity bit: high when polarity is 1, low when polarity is 0.
- R5: Writing the status word (offset 0) clears each bit written as 1 and leaves each bit written as 0. A level source whose input is still active reads 1 again after the clear.
- R6: The masked-status word (offset 6) reads status AND enable (offset 2).
- R7: irqNormal is high when any bit of status AND enable is set with its critical-select bit (offset 3) at 0.
- R8: irqCrit is high when any bit of status AND enable is set with its critical-select bit at 1.
- R9: Offsets other than 0, 2, 3, 4 (polarity), 5 (trigger), 6, 7 and 8 (vector words) read zero. A write to offset 6 changes no register.
- R10: An input change reaches the status word on the third rising clock edge after it is applied: two synchronizer stages, then the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Interrupt sources, index = source number |
| busAddr | input | ADDR_W | Register word offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for busAddr |
| irqNormal | output | 1 | Normal interrupt request |
| irqCrit | output | 1 | Critical interrupt request |

## Verification
The bench clears a level source while its input is still active and expects the bit to read 1 again. A design that lets the clear win for good would lose a live request. It clears an edge source while its input is high and expects the bit to stay 0, and it drives the opposite transition and expects no latch. A design that mixes up the two modes or the two polarities fails both checks. Reading exact status words for sources 0, 3, 10 and 31 catches a design that numbers the bits LSB-first. Writing all ones to the masked-status offset and then reading enable catches a decoder that aliases offset 6 onto a real register.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int OFF_STATUS  = 0;
  localparam int OFF_ENABLE  = 2;
  localparam int OFF_CRIT    = 3;
  localparam int OFF_POL     = 4;
  localparam int OFF_TRIG    = 5;
  localparam int OFF_MASKED  = 6;
  localparam int OFF_VEC     = 7;
  localparam int OFF_VEC_CFG = 8;

  typedef struct packed {
    logic status;
    logic enable;
    logic crit;
    logic pol;
    logic trig;
    logic vec;
    logic vecCfg;
  } wrStrobes_t;

  typedef enum logic [3:0] {
    RD_ZERO,
    RD_STATUS,
    RD_ENABLE,
    RD_CRIT,
    RD_POL,
    RD_TRIG,
    RD_MASKED,
    RD_VEC,
    RD_VEC_CFG
  } rdSel_e;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[0] <= '0;
          else       stageQ[0] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output wrStrobes_t        wrStb,
  output rdSel_e            rdSel
);

  always_comb begin
    wrStb = '0;
    rdSel = RD_ZERO;
    if (busAddr == ADDR_W'(OFF_STATUS)) begin
      rdSel        = RD_STATUS;
      wrStb.status = busWrEn;
    end else if (busAddr == ADDR_W'(OFF_ENABLE)) begin
      rdSel        = RD_ENABLE;
      wrStb.enable = busWrEn;
    end else if (busAddr == ADDR_W'(OFF_CRIT)) begin
      rdSel      = RD_CRIT;
      wrStb.crit = busWrEn;
    end else if (busAddr == ADDR_W'(OFF_POL)) begin
      rdSel     = RD_POL;
      wrStb.pol = busWrEn;
    end else if (busAddr == ADDR_W'(OFF_TRIG)) begin
      rdSel      = RD_TRIG;
      wrStb.trig = busWrEn;
    end else if (busAddr == ADDR_W'(OFF_MASKED)) begin
      rdSel = RD_MASKED;
    end else if (busAddr == ADDR_W'(OFF_VEC)) begin
      rdSel     = RD_VEC;
      wrStb.vec = busWrEn;
    end else if (busAddr == ADDR_W'(OFF_VEC_CFG)) begin
      rdSel        = RD_VEC_CFG;
      wrStb.vecCfg = busWrEn;
    end
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  wrStrobes_t         wrStb,
  input  rdSel_e             rdSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqNormal,
  output logic               irqCrit,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic [NUM_SRC-1:0] critQ,
  output logic [NUM_SRC-1:0] eventHit
);

  logic [NUM_SRC-1:0] srcBits;
  logic [NUM_SRC-1:0] syncQ;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] polQ;
  logic [NUM_SRC-1:0] trigQ;
  logic [DATA_W-1:0]  vecQ;
  logic [DATA_W-1:0]  vecCfgQ;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] maskedStat;
  logic [NUM_SRC-1:0] wrBits;

  assign wrBits = wrData[NUM_SRC-1:0];

  // Source n lands on bit NUM_SRC-1-n (MSB-first numbering)
  generate
    for (genvar n = 0; n < NUM_SRC; n++) begin : gMap
      assign srcBits[NUM_SRC-1-n] = srcIn[n];
    end
  endgenerate

  intc_sync #(
    .WIDTH (NUM_SRC),
    .STAGES(SYNC_STAGES)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (srcBits),
    .dout(syncQ)
  );

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ;
  end

  // Per-bit sensing rule
  generate
    for (genvar b = 0; b < NUM_SRC; b++) begin : gSense
      logic riseB, fallB, edgeB, levelB;
      assign riseB       = syncQ[b] & ~prevQ[b];
      assign fallB       = ~syncQ[b] & prevQ[b];
      assign edgeB       = polQ[b] ? riseB : fallB;
      assign levelB      = polQ[b] ? syncQ[b] : ~syncQ[b];
      assign eventHit[b] = trigQ[b] ? edgeB : levelB;
    end
  endgenerate

  assign clrMask = wrStb.status ? wrBits : '0;

  // A new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | eventHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      critQ   <= '0;
      polQ    <= '1;
      trigQ   <= '0;
      vecQ    <= '0;
      vecCfgQ <= '0;
    end else begin
      if (wrStb.enable) enableQ <= wrBits;
      if (wrStb.crit)   critQ   <= wrBits;
      if (wrStb.pol)    polQ    <= wrBits;
      if (wrStb.trig)   trigQ   <= wrBits;
      if (wrStb.vec)    vecQ    <= wrData;
      if (wrStb.vecCfg) vecCfgQ <= wrData;
    end
  end

  assign maskedStat = statusQ & enableQ;
  assign irqNormal  = |(maskedStat & ~critQ);
  assign irqCrit    = |(maskedStat & critQ);

  always_comb begin
    unique case (rdSel)
      RD_STATUS:  rdData = DATA_W'(statusQ);
      RD_ENABLE:  rdData = DATA_W'(enableQ);
      RD_CRIT:    rdData = DATA_W'(critQ);
      RD_POL:     rdData = DATA_W'(polQ);
      RD_TRIG:    rdData = DATA_W'(trigQ);
      RD_MASKED:  rdData = DATA_W'(maskedStat);
      RD_VEC:     rdData = vecQ;
      RD_VEC_CFG: rdData = vecCfgQ;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqNormal,
  output logic               irqCrit
);

  wrStrobes_t         wrStb;
  rdSel_e             rdSel;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] critQ;
  logic [NUM_SRC-1:0] eventHit;

  intc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .wrStb  (wrStb),
    .rdSel  (rdSel)
  );

  intc_datapath #(
    .NUM_SRC    (NUM_SRC),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .wrStb    (wrStb),
    .rdSel    (rdSel),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .irqNormal(irqNormal),
    .irqCrit  (irqCrit),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .critQ    (critQ),
    .eventHit (eventHit)
  );

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [DATA_W-1:0]  busWrData,
  input logic               irqNormal,
  input logic               irqCrit,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] enableQ,
  input logic [NUM_SRC-1:0] critQ,
  input logic [NUM_SRC-1:0] eventHit
);

  logic statusWr;
  logic maskedWr;
  assign statusWr = busWrEn && (busAddr == ADDR_W'(0));
  assign maskedWr = busWrEn && (busAddr == ADDR_W'(6));

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (statusQ == '0 && enableQ == '0 && !irqNormal && !irqCrit)); // R1

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $past(statusWr) |->
      ((statusQ & $past(busWrData[NUM_SRC-1:0]) & ~$past(eventHit)) == '0)); // R5

  AST_NO_SPONTANEOUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !$past(statusWr) |-> (($past(statusQ) & ~statusQ) == '0)); // R5

  AST_MASKED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    maskedWr |=> $stable(enableQ) && $stable(critQ)); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> (!irqNormal && !irqCrit)); // R6

  AST_ALL_CRIT_NO_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (critQ == '1) |-> !irqNormal); // R7

  AST_NO_CRIT_NO_CRITOUT: assert property (@(posedge clk) disable iff (!rstN)
    (critQ == '0) |-> !irqCrit); // R8

endmodule

bind intc_top intc_checker #(
  .NUM_SRC(NUM_SRC),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .irqNormal(irqNormal),
  .irqCrit  (irqCrit),
  .statusQ  (statusQ),
  .enableQ  (enableQ),
  .critQ    (critQ),
  .eventHit (eventHit)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;

  localparam int NUM_SRC = 32;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;

  logic               clk = 1'b0;
  logic               rstN;
  logic [NUM_SRC-1:0] srcIn;
  logic [ADDR_W-1:0]  busAddr;
  logic               busWrEn;
  logic [DATA_W-1:0]  busWrData;
  logic [DATA_W-1:0]  busRdData;
  logic               irqNormal;
  logic               irqCrit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intc_top #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqNormal(irqNormal), .irqCrit(irqCrit)
  );

  function automatic logic [31:0] bitOf(int src);
    return 32'h1 << (31 - src);
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(int addr, logic [31:0] data);
    busAddr   = ADDR_W'(addr);
    busWrData = data;
    busWrEn   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic bus_read(int addr, output logic [31:0] data);
    busAddr = ADDR_W'(addr);
    #1;
    data = busRdData;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    bus_read(0, d); check("R1", "status", d, 32'h0);
    bus_read(2, d); check("R1", "enable", d, 32'h0);
    bus_read(3, d); check("R1", "crit", d, 32'h0);
    bus_read(4, d); check("R1", "polarity", d, 32'hFFFF_FFFF);
    bus_read(5, d); check("R1", "trigger", d, 32'h0);
    bus_read(7, d); check("R1", "vector", d, 32'h0);
    bus_read(8, d); check("R1", "vector cfg", d, 32'h0);
    check("R1", "irq outputs", {30'h0, irqNormal, irqCrit}, 32'h0);
  endtask

  task automatic test_offsets();
    logic [31:0] d;
    bus_write(2, 32'h0000_00F0);
    bus_write(6, 32'hFFFF_FFFF);
    bus_read(2, d); check("R9", "enable after masked write", d, 32'h0000_00F0);
    bus_read(6, d); check("R9", "masked after masked write", d, 32'h0);
    bus_read(1, d); check("R9", "offset 1", d, 32'h0);
    bus_read(9, d); check("R9", "offset 9", d, 32'h0);
    bus_read(15, d); check("R9", "offset 15", d, 32'h0);
    bus_write(7, 32'hA5A5_0001);
    bus_read(7, d); check("R9", "vector storage", d, 32'hA5A5_0001);
    bus_write(2, 32'h0);
  endtask

  task automatic test_level_high();
    logic [31:0] d;
    bus_write(0, 32'hFFFF_FFFF);
    bus_write(2, bitOf(5));
    srcIn[5] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_read(0, d); check("R10", "status before third edge", d, 32'h0);
    wait_cycles(1);
    bus_read(0, d); check("R10", "status at third edge", d, bitOf(5));
    check("R2", "source 5 is bit 26", d, 32'h0400_0000);
    bus_read(6, d); check("R6", "masked level", d, bitOf(5));
    check("R7", "normal out", {31'h0, irqNormal}, 32'h1);
    bus_write(0, bitOf(5));
    bus_read(0, d); check("R5", "level re-set while active", d, bitOf(5));
    srcIn[5] = 1'b0;
    wait_cycles(4);
    bus_write(0, bitOf(5));
    bus_read(0, d); check("R4", "level cleared once inactive", d, 32'h0);
    check("R7", "normal out low", {31'h0, irqNormal}, 32'h0);
    bus_write(2, 32'h0);
  endtask

  task automatic test_level_low();
    logic [31:0] d;
    bus_write(4, ~bitOf(0));
    wait_cycles(2);
    bus_read(0, d); check("R4", "active-low source 0 sets", d, 32'h8000_0000);
    srcIn[0] = 1'b1;
    wait_cycles(4);
    bus_write(0, 32'hFFFF_FFFF);
    bus_read(0, d); check("R4", "active-low high input clears", d, 32'h0);
    srcIn[0] = 1'b0;
    wait_cycles(4);
    bus_read(0, d); check("R2", "source 0 is bit 31", d, 32'h8000_0000);
    bus_write(4, 32'hFFFF_FFFF);
    bus_write(0, 32'hFFFF_FFFF);
  endtask

  task automatic test_edge_rising();
    logic [31:0] d;
    bus_write(5, bitOf(10));
    bus_write(0, 32'hFFFF_FFFF);
    srcIn[10] = 1'b1;
    wait_cycles(4);
    bus_read(0, d); check("R3", "rising latch", d, 32'h0020_0000);
    bus_write(0, ~bitOf(10));
    bus_read(0, d); check("R5", "write zero keeps bit", d, bitOf(10));
    bus_write(0, bitOf(10));
    wait_cycles(2);
    bus_read(0, d); check("R3", "edge stays clear while high", d, 32'h0);
    srcIn[10] = 1'b0;
    wait_cycles(4);
    bus_read(0, d); check("R3", "falling ignored in rising mode", d, 32'h0);
  endtask

  task automatic test_edge_falling();
    logic [31:0] d;
    bus_write(5, bitOf(31));
    bus_write(4, ~bitOf(31));
    bus_write(0, 32'hFFFF_FFFF);
    srcIn[31] = 1'b1;
    wait_cycles(4);
    bus_read(0, d); check("R3", "rising ignored in falling mode", d, 32'h0);
    srcIn[31] = 1'b0;
    wait_cycles(4);
    bus_read(0, d); check("R3", "falling latch source 31 bit 0", d, 32'h0000_0001);
    bus_write(4, 32'hFFFF_FFFF);
    bus_write(5, 32'h0);
    bus_write(0, 32'hFFFF_FFFF);
  endtask

  task automatic test_critical();
    logic [31:0] d;
    srcIn[3] = 1'b1;
    wait_cycles(4);
    bus_read(0, d); check("R2", "source 3 is bit 28", d, 32'h1000_0000);
    check("R6", "disabled no outputs", {30'h0, irqNormal, irqCrit}, 32'h0);
    bus_write(2, bitOf(3));
    bus_write(3, bitOf(3));
    check("R8", "critical out", {30'h0, irqNormal, irqCrit}, 32'h1);
    bus_write(3, ~bitOf(3));
    check("R7", "normal out", {30'h0, irqNormal, irqCrit}, 32'h2);
    bus_write(2, ~bitOf(3));
    bus_read(6, d); check("R6", "masked disabled", d, 32'h0);
    check("R7", "outputs off when disabled", {30'h0, irqNormal, irqCrit}, 32'h0);
    srcIn[3] = 1'b0;
    bus_write(2, 32'h0);
    bus_write(3, 32'h0);
    wait_cycles(4);
    bus_write(0, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(10 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    srcIn = '0;
    busAddr = '0;
    busWrEn = 1'b0;
    busWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    wait_cycles(1);
    test_reset();
    test_offsets();
    test_level_high();
    test_level_low();
    test_edge_rising();
    test_edge_falling();
    test_critical();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule